// File: doc/BRIEF.md
# Two-Phase Pipeline Phase Sequencer

This block drives the timing of a three-stage pipelined converter in which one residue amplifier and one comparator bank are shared by the first two stages. It runs from a fast tick clock. Each sample period is built from two non-overlapping phases, Q1 and Q2. Each phase is split into a lead half and a tail half, and a short guard gap follows each phase. One sample period equals two cycles of the converter's external clock, so a 20 MHz external clock gives 10 MS/s.

From the current slot the block decodes these controls:
- the sampling enables for stage 1 and stage 2;
- the auto-zero and amplify windows, which pass the shared amplifier between the stages;
- the reference-sample window of the shared comparator bank and the strobes that select its stage-1 or stage-2 input;
- a start pulse for the final successive-approximation stage;
- a hold window that stalls that stage while the comparator bank moves from reference sampling to conversion.

It also produces one-tick strobes that tell the correction logic when each stage code is ready. A 2-bit code sets the length of the hold window. The code is captured once per period so that the window length never changes partway through a period.

Top module: `pipe_phase_seq`

## Requirements
- R1: While reset is asserted, and until the first rising clock edge after it is released, every output is low. That first edge starts the lead half of Q1, at period tick 0.
- R2: A period lasts 4*HALF_TICKS+2*GUARD_TICKS ticks. Q1 is high on ticks 0 to 2*HALF_TICKS-1. Q2 is high on ticks 2*HALF_TICKS+GUARD_TICKS to 4*HALF_TICKS+GUARD_TICKS-1. On the guard ticks neither phase is high, and Q1 and Q2 are never high together.
- R3: The stage-1 sample enable is high exactly while Q1 is high. The stage-2 sample enable is high exactly while Q2 is high.
- R4: The shared amplifier auto-zeros for stage 2 in the Q1 lead half and amplifies for stage 2 in the Q1 tail half. It auto-zeros for stage 1 in the Q2 lead half and amplifies for stage 1 in the Q2 tail half. At most one of these four controls is high at a time.
- R5: The comparator bank samples the reference in the lead half of both phases. Its stage-1 input select is high in the Q1 tail half, and its stage-2 input select is high in the Q2 tail half.
- R6: The final-stage start is a single-tick pulse on the first tick of Q2.
- R7: The final-stage hold window starts on the first tick of the Q2 tail half and lasts PAUSE_BASE + code ticks, where code is the unsigned 2-bit value on pause_code on the last clock edge of period tick 0. A change to pause_code later in a period does not affect that period's window.
- R8: Code-valid strobes last one tick each. The stage-1 strobe falls on the first guard tick after Q1, the stage-2 strobe on the first guard tick after Q2, and the stage-3 strobe on tick 0. No strobe is issued until one full period has elapsed after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pause_code | input | 2 | Hold-window length select, captured at period start |
| q1 | output | 1 | Phase Q1 |
| q2 | output | 1 | Phase Q2 |
| samp1 | output | 1 | Stage-1 input sampling enable |
| samp2 | output | 1 | Stage-2 residue sampling enable |
| az1 | output | 1 | Amplifier auto-zero for stage 1 |
| amp1 | output | 1 | Amplifier amplify for stage 1 |
| az2 | output | 1 | Amplifier auto-zero for stage 2 |
| amp2 | output | 1 | Amplifier amplify for stage 2 |
| ref_smp | output | 1 | Comparator bank reference sampling |
| cmp_sel1 | output | 1 | Comparator bank stage-1 input select |
| cmp_sel2 | output | 1 | Comparator bank stage-2 input select |
| sar_go | output | 1 | Final-stage conversion start pulse |
| sar_hold | output | 1 | Final-stage conversion hold window |
| code1_vld | output | 1 | Stage-1 code ready strobe |
| code2_vld | output | 1 | Stage-2 code ready strobe |
| code3_vld | output | 1 | Stage-3 code ready strobe |

## Verification
Every output is compared on every tick against a slot model worked out from the requirements. The runs cover a steady stream of periods with each of the four hold codes. Those runs separate a wrong hold length from a wrong hold start or a wrong slot boundary. A hold code changed while its window is active shows whether the code is captured once per period or followed live. A reset applied partway through a period, followed by a restart, shows whether the outputs clear at once and whether the warm-up period suppresses the code-ready strobes again.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic [2:0] {
      SL_Q1_LEAD,
      SL_Q1_TAIL,
      SL_GAP_A,
      SL_Q2_LEAD,
      SL_Q2_TAIL,
      SL_GAP_B
   } slot_e;

   typedef struct packed {
      logic q1;
      logic q2;
      logic samp1;
      logic samp2;
      logic az1;
      logic amp1;
      logic az2;
      logic amp2;
      logic ref_smp;
      logic cmp_sel1;
      logic cmp_sel2;
      logic sar_go;
      logic code1_vld;
      logic code2_vld;
      logic code3_vld;
   } phase_bus_t;

endpackage

// File: rtl/pps_timebase.sv
module pps_timebase
   import pps_pkg::*;
#(
   parameter int HALF_TICKS  = 4,
   parameter int GUARD_TICKS = 1,
   parameter int CNT_W       = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             run,
   output slot_e            slot,
   output logic [CNT_W-1:0] offset,
   output logic             at_start,
   output logic             wrap
);

   localparam int PERIOD = 4 * HALF_TICKS + 2 * GUARD_TICKS;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
   localparam logic [CNT_W-1:0] E_Q1T = CNT_W'(HALF_TICKS);
   localparam logic [CNT_W-1:0] E_GA  = CNT_W'(2 * HALF_TICKS);
   localparam logic [CNT_W-1:0] E_Q2L = CNT_W'(2 * HALF_TICKS + GUARD_TICKS);
   localparam logic [CNT_W-1:0] E_Q2T = CNT_W'(3 * HALF_TICKS + GUARD_TICKS);
   localparam logic [CNT_W-1:0] E_GB  = CNT_W'(4 * HALF_TICKS + GUARD_TICKS);

   logic [CNT_W-1:0] tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         tick <= '0;
      end else begin
         run <= 1'b1;
         if (run) begin
            tick <= (tick == LAST) ? '0 : tick + 1'b1;
         end
      end
   end

   always_comb begin
      if (tick < E_Q1T) begin
         slot   = SL_Q1_LEAD;
         offset = tick;
      end else if (tick < E_GA) begin
         slot   = SL_Q1_TAIL;
         offset = tick - E_Q1T;
      end else if (tick < E_Q2L) begin
         slot   = SL_GAP_A;
         offset = tick - E_GA;
      end else if (tick < E_Q2T) begin
         slot   = SL_Q2_LEAD;
         offset = tick - E_Q2L;
      end else if (tick < E_GB) begin
         slot   = SL_Q2_TAIL;
         offset = tick - E_Q2T;
      end else begin
         slot   = SL_GAP_B;
         offset = tick - E_GB;
      end
   end

   assign at_start = (tick == '0);
   assign wrap     = run && (tick == LAST);

endmodule

// File: rtl/pps_phase_decode.sv
module pps_phase_decode
   import pps_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             run,
   input  logic             primed,
   input  slot_e            slot,
   input  logic [CNT_W-1:0] offset,
   output phase_bus_t       bus
);

   logic first;

   assign first = (offset == '0);

   always_comb begin
      bus = '0;
      if (run) begin
         case (slot)
            SL_Q1_LEAD: begin
               bus.q1        = 1'b1;
               bus.samp1     = 1'b1;
               bus.az2       = 1'b1;
               bus.ref_smp   = 1'b1;
               bus.code3_vld = primed && first;
            end
            SL_Q1_TAIL: begin
               bus.q1       = 1'b1;
               bus.samp1    = 1'b1;
               bus.amp2     = 1'b1;
               bus.cmp_sel1 = 1'b1;
            end
            SL_GAP_A: begin
               bus.code1_vld = primed && first;
            end
            SL_Q2_LEAD: begin
               bus.q2      = 1'b1;
               bus.samp2   = 1'b1;
               bus.az1     = 1'b1;
               bus.ref_smp = 1'b1;
               bus.sar_go  = first;
            end
            SL_Q2_TAIL: begin
               bus.q2       = 1'b1;
               bus.samp2    = 1'b1;
               bus.amp1     = 1'b1;
               bus.cmp_sel2 = 1'b1;
            end
            SL_GAP_B: begin
               bus.code2_vld = primed && first;
            end
            default: bus = '0;
         endcase
      end
   end

endmodule

// File: rtl/pps_pause_gen.sv
module pps_pause_gen
   import pps_pkg::*;
#(
   parameter int CNT_W      = 5,
   parameter int CODE_W     = 2,
   parameter int PAUSE_BASE = 1,
   parameter bit PAUSE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              at_start,
   input  slot_e             slot,
   input  logic [CNT_W-1:0]  offset,
   input  logic [CODE_W-1:0] code,
   output logic              hold
);

   generate
      if (PAUSE_EN) begin : g_pause
         logic [CODE_W-1:0] code_q;
         logic [CNT_W-1:0]  limit;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code_q <= '0;
            end else if (at_start) begin
               code_q <= code;
            end
         end

         assign limit = CNT_W'(PAUSE_BASE) + CNT_W'(code_q);
         assign hold  = (slot == SL_Q2_TAIL) && (offset < limit);
      end else begin : g_no_pause
         logic unused_pause;
         assign unused_pause = ^{clk, rst_n, at_start, slot, offset, code};
         assign hold = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pipe_phase_seq.sv
module pipe_phase_seq
   import pps_pkg::*;
#(
   parameter int HALF_TICKS  = 4,
   parameter int GUARD_TICKS = 1,
   parameter int PAUSE_BASE  = 1,
   parameter int CODE_W      = 2,
   parameter bit PAUSE_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] pause_code,
   output logic              q1,
   output logic              q2,
   output logic              samp1,
   output logic              samp2,
   output logic              az1,
   output logic              amp1,
   output logic              az2,
   output logic              amp2,
   output logic              ref_smp,
   output logic              cmp_sel1,
   output logic              cmp_sel2,
   output logic              sar_go,
   output logic              sar_hold,
   output logic              code1_vld,
   output logic              code2_vld,
   output logic              code3_vld
);

   localparam int PERIOD    = 4 * HALF_TICKS + 2 * GUARD_TICKS;
   localparam int CNT_W     = $clog2(PERIOD + 1);
   localparam int MAX_PAUSE = PAUSE_BASE + (1 << CODE_W) - 1;

   generate
      if (HALF_TICKS < 2) begin : g_chk_half
         $error("pipe_phase_seq: HALF_TICKS must be at least 2");
      end
      if (GUARD_TICKS < 1) begin : g_chk_guard
         $error("pipe_phase_seq: GUARD_TICKS must be at least 1");
      end
      if (PAUSE_BASE < 1 || MAX_PAUSE > HALF_TICKS) begin : g_chk_pause
         $error("pipe_phase_seq: hold window must fit in a half phase");
      end
   endgenerate

   logic             run;
   logic             at_start;
   logic             wrap;
   logic             primed;
   slot_e            slot;
   logic [CNT_W-1:0] offset;
   phase_bus_t       bus;

   pps_timebase #(
      .HALF_TICKS (HALF_TICKS),
      .GUARD_TICKS(GUARD_TICKS),
      .CNT_W      (CNT_W)
   ) u_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .slot    (slot),
      .offset  (offset),
      .at_start(at_start),
      .wrap    (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed <= 1'b0;
      end else if (wrap) begin
         primed <= 1'b1;
      end
   end

   pps_phase_decode #(
      .CNT_W(CNT_W)
   ) u_decode (
      .run   (run),
      .primed(primed),
      .slot  (slot),
      .offset(offset),
      .bus   (bus)
   );

   pps_pause_gen #(
      .CNT_W     (CNT_W),
      .CODE_W    (CODE_W),
      .PAUSE_BASE(PAUSE_BASE),
      .PAUSE_EN  (PAUSE_EN)
   ) u_pause (
      .clk     (clk),
      .rst_n   (rst_n),
      .at_start(at_start),
      .slot    (slot),
      .offset  (offset),
      .code    (pause_code),
      .hold    (sar_hold)
   );

   assign q1        = bus.q1;
   assign q2        = bus.q2;
   assign samp1     = bus.samp1;
   assign samp2     = bus.samp2;
   assign az1       = bus.az1;
   assign amp1      = bus.amp1;
   assign az2       = bus.az2;
   assign amp2      = bus.amp2;
   assign ref_smp   = bus.ref_smp;
   assign cmp_sel1  = bus.cmp_sel1;
   assign cmp_sel2  = bus.cmp_sel2;
   assign sar_go    = bus.sar_go;
   assign code1_vld = bus.code1_vld;
   assign code2_vld = bus.code2_vld;
   assign code3_vld = bus.code3_vld;

endmodule

// File: rtl/pipe_phase_seq_chk.sv
module pipe_phase_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic q1,
   input logic q2,
   input logic az1,
   input logic amp1,
   input logic az2,
   input logic amp2,
   input logic ref_smp,
   input logic cmp_sel1,
   input logic cmp_sel2,
   input logic sar_go,
   input logic sar_hold,
   input logic code1_vld,
   input logic code2_vld
);

   a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(q1 && q2));

   a_r2_guard_after_q1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q1) |-> !q2);

   a_r4_amp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({az1, amp1, az2, amp2}));

   a_r5_cmp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ref_smp, cmp_sel1, cmp_sel2}));

   a_r6_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      sar_go |=> !sar_go);

   a_r6_go_at_q2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q2) |-> sar_go);

   a_r7_hold_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
      sar_hold |-> cmp_sel2);

   a_r7_hold_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sar_hold) |-> $past(ref_smp));

   a_r8_vld_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (code1_vld || code2_vld) |-> !(q1 || q2));

endmodule

bind pipe_phase_seq pipe_phase_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .q1       (q1),
   .q2       (q2),
   .az1      (az1),
   .amp1     (amp1),
   .az2      (az2),
   .amp2     (amp2),
   .ref_smp  (ref_smp),
   .cmp_sel1 (cmp_sel1),
   .cmp_sel2 (cmp_sel2),
   .sar_go   (sar_go),
   .sar_hold (sar_hold),
   .code1_vld(code1_vld),
   .code2_vld(code2_vld)
);

// File: tb/pipe_phase_seq_test.sv
module pipe_phase_seq_test;

   localparam int H  = 4;
   localparam int G  = 1;
   localparam int PB = 1;
   localparam int P  = 4 * H + 2 * G;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pause_code = 2'd0;
   logic q1, q2, samp1, samp2, az1, amp1, az2, amp2;
   logic ref_smp, cmp_sel1, cmp_sel2, sar_go, sar_hold;
   logic code1_vld, code2_vld, code3_vld;

   int checks = 0;
   int fails  = 0;
   int n      = 0;
   int exp_code = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pipe_phase_seq uut (
      .clk(clk), .rst_n(rst_n), .pause_code(pause_code),
      .q1(q1), .q2(q2), .samp1(samp1), .samp2(samp2),
      .az1(az1), .amp1(amp1), .az2(az2), .amp2(amp2),
      .ref_smp(ref_smp), .cmp_sel1(cmp_sel1), .cmp_sel2(cmp_sel2),
      .sar_go(sar_go), .sar_hold(sar_hold),
      .code1_vld(code1_vld), .code2_vld(code2_vld), .code3_vld(code3_vld)
   );

   function automatic logic [15:0] expv(int t, int per, int c);
      logic p1, p2, l1, l2, t1, t2, hold, pr;
      p1   = (t < 2 * H);
      p2   = (t >= 2 * H + G) && (t < 4 * H + G);
      l1   = (t < H);
      l2   = (t >= 2 * H + G) && (t < 3 * H + G);
      t1   = p1 && !l1;
      t2   = p2 && !l2;
      hold = t2 && ((t - (3 * H + G)) < (PB + c));
      pr   = (per >= 2);
      return {p1, p2, p1, p2, l2, t2, l1, t1, l1 || l2, t1, t2,
              (t == 2 * H + G), hold,
              pr && (t == 2 * H), pr && (t == 4 * H + G), pr && (t == 0)};
   endfunction

   function automatic string tagof(int b);
      if (b >= 14) return "R2";
      if (b >= 12) return "R3";
      if (b >= 8)  return "R4";
      if (b >= 5)  return "R5";
      if (b == 4)  return "R6";
      if (b == 3)  return "R7";
      return "R8";
   endfunction

   function automatic logic [15:0] actv();
      return {q1, q2, samp1, samp2, az1, amp1, az2, amp2, ref_smp,
              cmp_sel1, cmp_sel2, sar_go, sar_hold,
              code1_vld, code2_vld, code3_vld};
   endfunction

   function automatic int cur_t();
      return (n - 1) % P;
   endfunction

   task automatic check_zero(string sc);
      checks++;
      if (actv() !== 16'h0) begin
         fails++;
         $display("FAIL R1 %s: outputs actual=%h expected=%h", sc, actv(), 16'h0);
      end
   endtask

   task automatic step(string sc);
      logic [15:0] e, a;
      int t, per;
      @(posedge clk);
      @(negedge clk);
      n++;
      t   = cur_t();
      per = (n - 1) / P + 1;
      if (t == 0) exp_code = int'(pause_code);
      e = expv(t, per, exp_code);
      a = actv();
      checks++;
      if (a !== e) begin
         fails++;
         for (int b = 15; b >= 0; b--) begin
            if (a[b] !== e[b]) begin
               $display("FAIL %s %s: tick=%0d period=%0d bit=%0d actual=%h expected=%h",
                        tagof(b), sc, t, per, b, a, e);
               break;
            end
         end
      end
   endtask

   task automatic step_to(int tt, string sc);
      step(sc);
      while (cur_t() != tt) step(sc);
   endtask

   // R1: outputs low in reset and until the first edge after release
   task automatic t_reset(string sc);
      rst_n = 1'b0;
      #1;
      check_zero(sc);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check_zero(sc);
      end
      rst_n = 1'b1;
      n = 0;
      #1;
      check_zero(sc);
   endtask

   // R2..R6, R8: steady periods with the warm-up period first
   task automatic t_periods(int k, string sc);
      for (int i = 0; i < k * P; i++) step(sc);
   endtask

   // R7: each hold code gives its own window length
   task automatic t_code_sweep();
      for (int c = 0; c < 4; c++) begin
         step_to(3, "R7 code sweep");
         pause_code = 2'(c);
         step_to(P - 1, "R7 code sweep");
         t_periods(2, "R7 code sweep");
      end
   endtask

   // R7: code change inside an active window only takes effect next period
   task automatic t_code_mid();
      step_to(3, "R7 mid change");
      pause_code = 2'd0;
      step_to(P - 1, "R7 mid change");
      step_to(3 * H + G, "R7 mid change");
      pause_code = 2'd3;
      step_to(P - 1, "R7 mid change");
      t_periods(1, "R7 mid change");
   endtask

   // R1, R8: reset partway through a period, then warm-up again
   task automatic t_mid_reset();
      step_to(10, "R1 mid reset");
      t_reset("R1 mid reset");
      t_periods(3, "R8 restart warm-up");
   endtask

   initial begin
      t_reset("R1 power-on");
      t_periods(3, "R2 steady code0");
      t_code_sweep();
      t_code_mid();
      t_mid_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule